// File: doc/BRIEF.md
# Sleep Entry and Recovery Controller for a Synchronous RAM Core

This block sits between a synchronous RAM core and the rest of its chip and manages the core's low-power sleep. It takes an asynchronous, active-high sleep request and passes it through a flop synchronizer. A four-state machine (awake, entering, asleep, recovering) then drives the core's clock enable, a forced-deselect line and a high-impedance request for the data output. Going into sleep and coming out of it each pass through a guard window of a fixed number of clock cycles. During that window, access strobes and write signals are kept away from the core.

If an access strobe or a write arrives inside a guard window, the block suppresses it and raises a sticky violation flag. While the core is fully asleep, inputs may toggle freely: nothing reaches the core and no violation is recorded. When the request is released and recovery ends, the controller returns to normal operation. A low-power indication stays raised until the first read or write command arrives. All pins are plain control and status lines, with no data stream and therefore no back-pressure. An unconnected request input is meant to be pulled low, which keeps the block awake.

Top module: `sleep_guard_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after reset: `core_clk_en_o`=1, `force_desel_o`=0, `dq_hiz_o`=0, `low_power_o`=0, `violation_o`=0.
- R2: The request passes through SYNC_STAGES flops. Once the synchronized request is seen high while awake, the block enters the entry window on the next edge, and `force_desel_o` is 1 from that cycle on.
- R3: The entry window lasts exactly GUARD_CYCLES cycles, during which `core_clk_en_o` stays 1. The block is then asleep, with `core_clk_en_o`=0.
- R4: While asleep: `core_clk_en_o`=0, `force_desel_o`=1 and `dq_hiz_o`=1. Strobes and writes pass nothing through and set no violation.
- R5: Once the synchronized request is seen low while asleep, a recovery window of exactly GUARD_CYCLES cycles follows, with `core_clk_en_o`=1 and `force_desel_o`=1. The block is then awake and `force_desel_o`=0.
- R6: `low_power_o` rises together with the asleep state. It stays 1 through recovery and while awake with no command. It falls on the edge after the first awake cycle with `strobe_i` or `write_i` high.
- R7: During an entry or recovery window, `strobe_ok_o` and `write_ok_o` are 0 whatever `strobe_i` and `write_i` do.
- R8: `violation_o` rises on the edge after any cycle in an entry or recovery window that has `strobe_i` or `write_i` high. It then stays 1 until reset.
- R9: While awake, `strobe_ok_o` equals `strobe_i` and `write_ok_o` equals `write_i` in the same cycle.
- R10: An entry window, once started, always runs to the asleep state, even if the request falls during it. Recovery then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| strobe_i | input | 1 | Access strobe (start of a read or write command) |
| write_i | input | 1 | Write signal |
| strobe_ok_o | output | 1 | Strobe as passed on to the core |
| write_ok_o | output | 1 | Write as passed on to the core |
| core_clk_en_o | output | 1 | Clock enable for the RAM core |
| force_desel_o | output | 1 | Forces the core deselected |
| dq_hiz_o | output | 1 | Requests high impedance on the data output |
| low_power_o | output | 1 | Low-power state indication |
| violation_o | output | 1 | Sticky flag for an access inside a guard window |

## Verification
A state machine stuck in the wrong state, or a guard counter off by one, moves the fall or rise of `core_clk_en_o` and `force_desel_o` by a cycle. The bench's per-clock model sees that within one clock of the window edge. A wrong synchronizer depth shifts every transition after a request edge, and a badly handled low-power hold shows up as `low_power_o` falling early or never. Blocking that leaks in a guard window shows as `strobe_ok_o` or `write_ok_o` high in that same cycle. A violation flag that is not sticky, or is set while asleep, differs from the model on the following edge.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE      = 2'd0,
    ST_ENTERING   = 2'd1,
    ST_ASLEEP     = 2'd2,
    ST_RECOVERING = 2'd3
  } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= async_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/slp_timer.sv
module slp_timer #(
  parameter int GUARD = 2,
  localparam int CW = $clog2(GUARD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] CLAST = CW'(GUARD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr_i) cnt <= '0;
    else if (run_i && cnt != CMAX) cnt <= cnt + 1'b1;
  end

  assign done_o = run_i && (cnt == CLAST);

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt == '0)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1)); // R5
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int GUARD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s_i,
  input  logic       cmd_i,
  output slp_state_e state_o,
  output logic       low_power_o,
  output logic       violation_o
);
  slp_state_e state, state_nx;
  logic in_window, win_done, lp_q, viol_q;

  assign in_window = (state == ST_ENTERING) || (state == ST_RECOVERING);

  slp_timer #(.GUARD(GUARD)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!in_window),
    .run_i  (in_window),
    .done_o (win_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_AWAKE:      if (req_s_i)  state_nx = ST_ENTERING;
      ST_ENTERING:   if (win_done) state_nx = ST_ASLEEP;
      ST_ASLEEP:     if (!req_s_i) state_nx = ST_RECOVERING;
      ST_RECOVERING: if (win_done) state_nx = ST_AWAKE;
      default:       state_nx = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_AWAKE;
      lp_q   <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_ENTERING && win_done) lp_q <= 1'b1;
      else if (state == ST_AWAKE && cmd_i && !req_s_i) lp_q <= 1'b0;
      else if (state == ST_AWAKE && cmd_i) lp_q <= 1'b0;
      if (in_window && cmd_i) viol_q <= 1'b1;
    end
  end

  assign state_o     = state;
  assign low_power_o = lp_q;
  assign violation_o = viol_q;

  AST_ENTER_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AWAKE && req_s_i) |=> (state == ST_ENTERING)); // R2
  AST_SLEEP_VIA_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ASLEEP) |=> (state != ST_ASLEEP || $past(state) == ST_ENTERING)); // R3
  AST_ENTRY_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTERING) |=> (state == ST_ENTERING || state == ST_ASLEEP)); // R10
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    violation_o |=> violation_o); // R8
  AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power_o && !(state == ST_AWAKE && cmd_i)) |=> low_power_o); // R6
endmodule

// File: rtl/slp_gate.sv
module slp_gate
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slp_state_e state_i,
  input  logic       strobe_i,
  input  logic       write_i,
  output logic       strobe_ok_o,
  output logic       write_ok_o,
  output logic       core_clk_en_o,
  output logic       force_desel_o,
  output logic       dq_hiz_o
);
  logic open_q;

  always_comb begin
    open_q        = (state_i == ST_AWAKE);
    core_clk_en_o = (state_i != ST_ASLEEP);
    force_desel_o = !open_q;
    dq_hiz_o      = (state_i == ST_ASLEEP);
    strobe_ok_o   = strobe_i && open_q;
    write_ok_o    = write_i && open_q;
  end

  AST_NO_PASS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    force_desel_o |-> (!strobe_ok_o && !write_ok_o)); // R7
  AST_CLK_OFF_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en_o |-> (force_desel_o && dq_hiz_o)); // R4
endmodule

// File: rtl/sleep_guard_ctrl.sv
module sleep_guard_ctrl
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int GUARD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req_i,
  input  logic strobe_i,
  input  logic write_i,
  output logic strobe_ok_o,
  output logic write_ok_o,
  output logic core_clk_en_o,
  output logic force_desel_o,
  output logic dq_hiz_o,
  output logic low_power_o,
  output logic violation_o
);
  logic       req_s;
  slp_state_e state;

  slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sleep_req_i),
    .sync_o  (req_s)
  );

  slp_fsm #(.GUARD(GUARD_CYCLES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_s_i     (req_s),
    .cmd_i       (strobe_i || write_i),
    .state_o     (state),
    .low_power_o (low_power_o),
    .violation_o (violation_o)
  );

  slp_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_i       (state),
    .strobe_i      (strobe_i),
    .write_i       (write_i),
    .strobe_ok_o   (strobe_ok_o),
    .write_ok_o    (write_ok_o),
    .core_clk_en_o (core_clk_en_o),
    .force_desel_o (force_desel_o),
    .dq_hiz_o      (dq_hiz_o)
  );

  AST_LP_WHEN_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    dq_hiz_o |-> low_power_o); // R6
endmodule

// File: tb/sim_sleep_guard_ctrl.sv
module sim_sleep_guard_ctrl;
  localparam int SYNC  = 2;
  localparam int GUARD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req_i = 1'b0, strobe_i = 1'b0, write_i = 1'b0;
  logic strobe_ok_o, write_ok_o, core_clk_en_o, force_desel_o;
  logic dq_hiz_o, low_power_o, violation_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  bit saw_sleep = 0;

  always #2 clk = ~clk;

  sleep_guard_ctrl #(.SYNC_STAGES(SYNC), .GUARD_CYCLES(GUARD)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i),
    .strobe_i(strobe_i), .write_i(write_i),
    .strobe_ok_o(strobe_ok_o), .write_ok_o(write_ok_o),
    .core_clk_en_o(core_clk_en_o), .force_desel_o(force_desel_o),
    .dq_hiz_o(dq_hiz_o), .low_power_o(low_power_o), .violation_o(violation_o));

  // Behavioural reference: 0 awake, 1 entering, 2 asleep, 3 recovering
  int m_st = 0, m_el = 0;
  bit m_lp = 0, m_viol = 0;
  bit q[$];

  initial for (int i = 0; i < SYNC; i++) q.push_back(1'b0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_el = 0; m_lp = 0; m_viol = 0;
      q.delete();
      for (int i = 0; i < SYNC; i++) q.push_back(1'b0);
    end else begin
      bit rs, cmd;
      rs  = q[$];
      cmd = strobe_i || write_i;
      case (m_st)
        0: begin
          if (cmd) m_lp = 0;
          if (rs) begin m_st = 1; m_el = 0; end
        end
        1: begin
          if (cmd) m_viol = 1;
          if (m_el == GUARD-1) begin m_st = 2; m_lp = 1; end else m_el++;
        end
        2: if (!rs) begin m_st = 3; m_el = 0; end
        default: begin
          if (cmd) m_viol = 1;
          if (m_el == GUARD-1) m_st = 0; else m_el++;
        end
      endcase
      q.push_front(sleep_req_i);
      void'(q.pop_back());
    end
  end

  task automatic chk(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, name, act, exp, $time);
    end
  endtask

  // Compare every cycle, 1 ns after the falling edge where inputs change
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk((m_st == 2) ? "R4" : "R3", "core_clk_en", core_clk_en_o, m_st != 2);
      chk((m_st == 3) ? "R5" : "R2", "force_desel", force_desel_o, m_st != 0);
      chk("R4", "dq_hiz", dq_hiz_o, m_st == 2);
      chk("R6", "low_power", low_power_o, m_lp);
      chk("R8", "violation", violation_o, m_viol);
      chk((m_st == 0) ? "R9" : "R7", "strobe_ok", strobe_ok_o, strobe_i && m_st == 0);
      chk((m_st == 0) ? "R9" : "R7", "write_ok", write_ok_o, write_i && m_st == 0);
      if (m_st == 2) saw_sleep = 1;
    end
  end

  task automatic step(bit s, bit w, int n);
    repeat (n) begin
      @(negedge clk);
      strobe_i = s; write_i = w;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset values
    #3;
    chk("R1", "rst clk_en", core_clk_en_o, 1'b1);
    chk("R1", "rst desel", force_desel_o, 1'b0);
    chk("R1", "rst hiz", dq_hiz_o, 1'b0);
    chk("R1", "rst lp", low_power_o, 1'b0);
    chk("R1", "rst viol", violation_o, 1'b0);
    step(0, 0, 3);
    rst_n = 1'b1;
    step(0, 0, 2);
    // R9: awake pass-through
    step(1, 0, 1); step(0, 1, 1); step(1, 1, 2); step(0, 0, 1);
    // R2/R3/R4: clean entry, toggling while asleep
    @(negedge clk); sleep_req_i = 1'b1;
    step(0, 0, SYNC + GUARD + 1);
    step(1, 0, 1); step(0, 1, 1); step(1, 1, 2); step(0, 0, 1);
    chk("R4", "asleep no violation", violation_o, 1'b0);
    // R5/R6: release, recover, low power held until a command
    @(negedge clk); sleep_req_i = 1'b0;
    step(0, 0, SYNC + GUARD + 4);
    #1 chk("R6", "lp held after recovery", low_power_o, 1'b1);
    step(1, 0, 1); step(0, 0, 2);
    #1 chk("R6", "lp cleared by command", low_power_o, 1'b0);
    // R7/R8: access inside entry window
    @(negedge clk); sleep_req_i = 1'b1;
    step(0, 0, SYNC);
    step(1, 0, 1); step(0, 0, GUARD + 2);
    #1 chk("R8", "violation after entry access", violation_o, 1'b1);
    @(negedge clk); sleep_req_i = 1'b0;
    step(0, 0, SYNC);
    step(0, 1, 1); step(0, 0, GUARD + 3);
    #1 chk("R8", "violation still set", violation_o, 1'b1);
    // R8: only reset clears it
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R8", "violation cleared by reset", violation_o, 1'b0);
    step(0, 0, 2); rst_n = 1'b1;
    step(0, 0, 2);
    // R10: one-cycle request pulse still completes entry
    saw_sleep = 0;
    @(negedge clk); sleep_req_i = 1'b1;
    @(negedge clk); sleep_req_i = 1'b0;
    step(0, 0, SYNC + 2 * GUARD + 6);
    chk("R10", "short pulse reached sleep", saw_sleep, 1'b1);
    #1 chk("R10", "back awake", force_desel_o, 1'b0);
    finish_run();
  end
endmodule